// File: doc/BRIEF.md
# PWM Channel with Fractional Duty

This block is one PWM output channel. It follows the count of one of four shared timers, chosen by a two-bit select field. The output rises when the chosen count equals a programmed high point. It falls again once the count reaches a low point, which is the high point plus an integer duty length. In some periods one more count is added to that low point. A four-bit fractional duty field sets how many periods get the extra count. Across sixteen periods this gives an average pulse width with a resolution of one sixteenth of a count.

The high point and the duty word are sampled only when the selected timer overflows. A period therefore always runs with one consistent setting. A four-bit phase counter also steps on each of those overflows, and it decides which periods receive the extra count. When the output enable is low, the pin carries a programmed idle level. After the enable comes back, the channel waits for the next high-point match before it drives the pin again.

Top module: `pwm_frac_channel`

## Requirements
- R1: `tmr_sel_i` chooses the timer that the channel follows: 0 selects timer 0, 1 selects timer 1, 2 selects timer 2 and 3 selects timer 3. Timer i drives `tmr_cnt_i[20*i+19:20*i]` and `tmr_ovf_i[i]`.
- R2: In the first cycle after `out_en_i` is sampled low, `pwm_o` equals `idle_lvl_i`, and it keeps following `idle_lvl_i` while the enable stays low.
- R3: When the channel is running and the selected count equals the latched high point, `pwm_o` is 1 in the next cycle.
- R4: The low point is latched high point + `duty_i[24:4]` + extra, computed without wrap. `pwm_o` is 0 in the cycle after the count equals the low point. If the low point equals the high point, no pulse is produced. If the counter never reaches the low point, the output stays high.
- R5: Let f = `duty_i[3:0]`. A period that uses phase p gets extra = 1 exactly when ((p*f) mod 16) + f >= 16, and 0 otherwise. So exactly f of every 16 consecutive periods are one count longer.
- R6: The 4-bit phase is 0 after reset. It advances by one on every selected overflow. The period that starts after the n-th selected overflow since reset (n >= 1) uses phase (n-1) mod 16.
- R7: `hi_pt_i` and `duty_i` take effect only at a selected overflow. A change made in the middle of a period does not alter that period.
- R8: After `out_en_i` returns high, `pwm_o` stays at `idle_lvl_i` until the next high-point match, even if the count is already between the high and low points.
- R9: After reset the channel is not running and `pwm_o` equals `idle_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt_i | input | 80 | Four timer counts, 20 bits each, timer 0 in the low bits |
| tmr_ovf_i | input | 4 | One overflow strobe per timer, high in the last cycle of a timer period |
| tmr_sel_i | input | 2 | Timer select |
| out_en_i | input | 1 | Output enable |
| idle_lvl_i | input | 1 | Pin level while the channel is not running |
| hi_pt_i | input | 20 | High point |
| duty_i | input | 25 | Duty: integer length in [24:4], fraction in [3:0] |
| pwm_o | output | 1 | PWM pin |

## Verification
The assertions assume that the selected timer advances by at most one count per clock. They also assume that the overflow strobe is high in the last cycle of a period, just before the count returns to zero. The bench meets both conditions with free-running timer models of different lengths, each counting from zero to its period minus one. Settings and the select field change only at falling clock edges. Every new setting is followed by one discarded period before any measurement, so the next overflow has latched it before it is checked.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int PKG_NUM_TMR = 4;
  localparam int PKG_CNT_W   = 20;
  localparam int PKG_FRAC_W  = 4;
endpackage

// File: rtl/pwm_tmr_mux.sv
module pwm_tmr_mux #(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 20,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt_i,
  input  logic [NUM_TMR-1:0]       tmr_ovf_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     ovf_o
);
  logic [CNT_W-1:0] cnt_arr [NUM_TMR];

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_slice
    assign cnt_arr[g] = tmr_cnt_i[g*CNT_W +: CNT_W];
  end

  always_comb begin
    cnt_o = '0;
    ovf_o = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (SEL_W'(i) == sel_i) begin
        cnt_o = cnt_arr[i];
        ovf_o = tmr_ovf_i[i];
      end
    end
  end
endmodule

// File: rtl/pwm_frac_sched.sv
module pwm_frac_sched #(
  parameter int CNT_W  = 20,
  parameter int FRAC_W = 4,
  localparam int DUTY_W = CNT_W + 1 + FRAC_W,
  localparam int LO_W   = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_i,
  input  logic [CNT_W-1:0]  hi_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  hi_o,
  output logic [LO_W-1:0]   lo_o
);
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W-1:0] mix;
  logic              extra;
  logic [LO_W-1:0]   lo_next;

  assign frac  = duty_i[FRAC_W-1:0];
  // low bits of phase*frac plus frac carry out exactly when mix > ~frac
  assign mix   = phase_q * frac;
  assign extra = (mix > ~frac);
  assign lo_next = LO_W'(hi_i) + LO_W'(duty_i[DUTY_W-1:FRAC_W]) + LO_W'(extra);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      hi_o    <= '0;
      lo_o    <= '0;
    end else if (ovf_i) begin
      phase_q <= phase_q + 1'b1;
      hi_o    <= hi_i;
      lo_o    <= lo_next;
    end
  end

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_i |=> ($stable(hi_o) && $stable(lo_o)));

  assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> (phase_q == FRAC_W'($past(phase_q) + 1'b1)));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 20,
  parameter int LO_W  = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic             en_i,
  input  logic             idle_i,
  output logic             pwm_o
);
  logic run_q;
  logic act_q;
  logic hit_hi;
  logic hit_lo;

  assign hit_hi = (cnt_i == hi_i);
  assign hit_lo = (LO_W'(cnt_i) == lo_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (hit_hi) run_q <= 1'b1;
      if (hit_hi && !hit_lo) act_q <= 1'b1;
      else if (hit_lo)       act_q <= 1'b0;
    end
  end

  assign pwm_o = run_q ? act_q : idle_i;

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pwm_o == idle_i));

  assert_rise_at_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(hit_hi) && !$past(hit_lo)));

  assert_fall_at_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(act_q) && $past(en_i)) |-> $past(hit_lo));

  assert_rearm_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(hit_hi));
endmodule

// File: rtl/pwm_frac_channel.sv
module pwm_frac_channel
  import pwm_frac_pkg::*;
#(
  parameter int NUM_TMR = PKG_NUM_TMR,
  parameter int CNT_W   = PKG_CNT_W,
  parameter int FRAC_W  = PKG_FRAC_W,
  localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
  localparam int DUTY_W = CNT_W + 1 + FRAC_W,
  localparam int LO_W   = CNT_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt_i,
  input  logic [NUM_TMR-1:0]       tmr_ovf_i,
  input  logic [SEL_W-1:0]         tmr_sel_i,
  input  logic                     out_en_i,
  input  logic                     idle_lvl_i,
  input  logic [CNT_W-1:0]         hi_pt_i,
  input  logic [DUTY_W-1:0]        duty_i,
  output logic                     pwm_o
);
  logic [CNT_W-1:0] sel_cnt;
  logic             sel_ovf;
  logic [CNT_W-1:0] hi_sh;
  logic [LO_W-1:0]  lo_sh;

  pwm_tmr_mux #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_mux (
    .tmr_cnt_i(tmr_cnt_i),
    .tmr_ovf_i(tmr_ovf_i),
    .sel_i    (tmr_sel_i),
    .cnt_o    (sel_cnt),
    .ovf_o    (sel_ovf)
  );

  pwm_frac_sched #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_sched (
    .clk   (clk),
    .rst_n (rst_n),
    .ovf_i (sel_ovf),
    .hi_i  (hi_pt_i),
    .duty_i(duty_i),
    .hi_o  (hi_sh),
    .lo_o  (lo_sh)
  );

  pwm_out_stage #(.CNT_W(CNT_W), .LO_W(LO_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_i (sel_cnt),
    .hi_i  (hi_sh),
    .lo_i  (lo_sh),
    .en_i  (out_en_i),
    .idle_i(idle_lvl_i),
    .pwm_o (pwm_o)
  );

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> (pwm_o == idle_lvl_i));
endmodule

// File: tb/pwm_frac_channel_tb.sv
`timescale 1ns/1ps
module pwm_frac_channel_tb_top;
  localparam int CW = 20;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NT*CW-1:0] tcnt_flat;
  logic [NT-1:0]    tovf;
  logic [1:0]       sel = 2'd0;
  logic             en = 1'b0;
  logic             idle = 1'b1;
  logic [19:0]      hi = '0;
  logic [24:0]      duty = '0;
  logic             pwm;

  int per [NT] = '{64, 40, 48, 56};
  logic [CW-1:0] tcnt [NT];
  int ovf_n;
  int checks = 0;
  int fails = 0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NT; i++) begin
      if (!rst_n) tcnt[i] <= '0;
      else tcnt[i] <= (tcnt[i] == CW'(per[i] - 1)) ? '0 : tcnt[i] + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      tovf[i] = (tcnt[i] == CW'(per[i] - 1));
      tcnt_flat[i*CW +: CW] = tcnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_n <= 0;
    else if (tovf[sel]) ovf_n <= ovf_n + 1;
  end

  pwm_frac_channel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_cnt_i (tcnt_flat),
    .tmr_ovf_i (tovf),
    .tmr_sel_i (sel),
    .out_en_i  (en),
    .idle_lvl_i(idle),
    .hi_pt_i   (hi),
    .duty_i    (duty),
    .pwm_o     (pwm)
  );

  function automatic int cur_cnt();
    return int'(tcnt[sel]);
  endfunction

  function automatic int extra_of(int p, int f);
    return ((((p * f) % 16) + f) >= 16) ? 1 : 0;
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_cfg(int h, int di, int f);
    hi   = 20'(h);
    duty = 25'((di << 4) | (f & 15));
  endtask

  task automatic wait_cnt(int c);
    do @(negedge clk); while (cur_cnt() != c);
  endtask

  task automatic run_period(input int chg_at, input int nh, input int nd,
                            output int highs, output int first, output int ph);
    wait_cnt(0);
    ph = (ovf_n - 1) % 16;
    highs = 0;
    first = -1;
    for (int i = 0; i < per[sel]; i++) begin
      if (i > 0) @(negedge clk);
      if (i == chg_at) begin
        hi   = 20'(nh);
        duty = 25'(nd);
      end
      if (pwm) begin
        highs++;
        if (first < 0) first = cur_cnt();
      end
    end
  endtask

  task automatic skip_period();
    int h, f, p;
    run_period(-1, 0, 0, h, f, p);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en = 1'b0;
    idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "pwm after reset", int'(pwm), 1);
    idle = 1'b0;
    @(negedge clk);
    chk("R2", "idle level follows while off", int'(pwm), 0);
  endtask

  task automatic t_integer();
    int h, f, p;
    sel = 2'd0;
    en = 1'b1;
    set_cfg(10, 20, 0);
    skip_period();
    for (int k = 0; k < 3; k++) begin
      run_period(-1, 0, 0, h, f, p);
      chk("R3", "rise position", f, 11);
      chk("R4", "pulse width integer duty", h, 20);
    end
  endtask

  task automatic t_zero_and_full();
    int h, f, p;
    set_cfg(10, 0, 0);
    skip_period();
    run_period(-1, 0, 0, h, f, p);
    chk("R4", "zero duty gives no pulse", h, 0);
    set_cfg(10, 100, 0);
    skip_period();
    run_period(-1, 0, 0, h, f, p);
    chk("R4", "unreached low point keeps output high", h, per[0]);
    set_cfg(10, 20, 0);
    skip_period();
    skip_period();
  endtask

  task automatic t_fraction();
    int h, f, p, tot;
    set_cfg(10, 20, 5);
    skip_period();
    tot = 0;
    for (int k = 0; k < 16; k++) begin
      run_period(-1, 0, 0, h, f, p);
      chk("R5 R6", $sformatf("width at phase %0d frac 5", p), h, 20 + extra_of(p, 5));
      tot += h - 20;
    end
    chk("R5", "extra periods per 16 frac 5", tot, 5);
    set_cfg(10, 0, 15);
    skip_period();
    tot = 0;
    for (int k = 0; k < 16; k++) begin
      run_period(-1, 0, 0, h, f, p);
      tot += h;
    end
    chk("R5", "total high counts frac 15 integer 0", tot, 15);
  endtask

  task automatic t_select();
    int h, f, p;
    for (int s = 0; s < NT; s++) begin
      sel = 2'(s);
      set_cfg(10 + s, 20, 0);
      skip_period();
      skip_period();
      run_period(-1, 0, 0, h, f, p);
      chk("R1", $sformatf("rise position timer %0d", s), f, 11 + s);
      chk("R1", $sformatf("width timer %0d", s), h, 20);
    end
    sel = 2'd0;
  endtask

  task automatic t_shadow();
    int h, f, p;
    set_cfg(10, 20, 0);
    skip_period();
    run_period(20, 4, 8 << 4, h, f, p);
    chk("R7", "mid-period change leaves rise", f, 11);
    chk("R7", "mid-period change leaves width", h, 20);
    run_period(-1, 0, 0, h, f, p);
    chk("R7", "new rise next period", f, 5);
    chk("R7", "new width next period", h, 8);
  endtask

  task automatic t_disable();
    int bad;
    set_cfg(10, 20, 0);
    idle = 1'b0;
    skip_period();
    wait_cnt(15);
    chk("R3", "high inside pulse", int'(pwm), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R2", "drop to idle 0 after disable", int'(pwm), 0);
    idle = 1'b1;
    @(negedge clk);
    chk("R2", "idle 1 while disabled", int'(pwm), 1);
    wait_cnt(20);
    en = 1'b1;
    bad = 0;
    for (int i = 0; i < 2 * per[0]; i++) begin
      @(negedge clk);
      if (cur_cnt() == 11) break;
      if (pwm != 1'b1) bad++;
    end
    chk("R8", "cycles off idle before match", bad, 0);
    chk("R8", "high after match", int'(pwm), 1);
    wait_cnt(31);
    chk("R8", "low after low point", int'(pwm), 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_integer();
    t_zero_and_full();
    t_fraction();
    t_select();
    t_shadow();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule